// File: doc/BRIEF.md
# Calorimeter Trigger Primitive Datapath

This block turns the raw front-end codes of a group of calorimeter channels into one compact trigger word per bunch crossing. Every channel's code indexes its own programmable linearizing table, which yields a 10-bit linear transverse energy. The linear energies of all channels are added with saturation. The sum then indexes a compressing table that gives a 7-bit energy code. A muon flag travels alongside the data. A no-shower table, indexed by the compressed code, can veto that flag where shower leakage would otherwise fake a muon.

The datapath accepts one sample per clock and always answers three clocks later, with a valid flag that follows the data. A small configuration port writes any entry of any table and reads it back. A write made while samples are streaming affects only samples presented at a later edge. After reset every table holds identity contents.

Top module: `tpgPrimitive`

## Requirements
- R1: After reset, input-table entry e of every channel holds e, compression entry s holds min(s,127), and every no-shower entry holds 1. With these contents the output energy is min(sum of raw codes,127) and the muon flag passes unchanged.
- R2: Selector 0 writes the input table. Address bits [7:6] pick the channel and bits [5:0] pick the code. The data bits [9:0] are written. A write changes only that channel's entry.
- R3: The sum of the linear channel energies saturates at 1023 and never wraps.
- R4: Selector 1 writes compression entry cfgAddr[9:0] with cfgWrData[6:0]. The output energy code is that entry for the saturated sum.
- R5: Selector 2 writes no-shower entry cfgAddr[6:0] with cfgWrData[0]. outMuon equals the input muon flag AND the no-shower entry at the output energy code.
- R6: A sample presented with inValid at clock edge k appears on the outputs after edge k+2, so it is visible in the cycle after the third edge. outValid reproduces inValid with the same delay, and one sample is accepted every clock.
- R7: cfgRdData shows the entry addressed by cfgSel/cfgAddr one clock after they are presented. Narrower entries are zero-extended.
- R8: A table write takes effect for lookups at later edges. A sample whose lookup shares the edge of the write still sees the old entry.
- R9: During reset and right after it, outValid, outEt and outMuon are 0.
- R10: Selector 3 writes nothing and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Sample valid |
| inCodes | input | 24 | Raw codes; channel c in bits [6c+5:6c] |
| inMuon | input | 1 | Muon flag for the sample |
| cfgSel | input | 2 | Table select: 0 input, 1 compression, 2 no-shower, 3 none |
| cfgAddr | input | 10 | Table entry address |
| cfgWrEn | input | 1 | Write strobe |
| cfgWrData | input | 10 | Write data |
| cfgRdData | output | 10 | Registered read-back data |
| outValid | output | 1 | Result valid |
| outEt | output | 7 | Compressed energy code |
| outMuon | output | 1 | Muon flag after no-shower veto |

## Verification
A configuration write to an input-table entry can land on the same clock edge as the lookup of a sample that uses that entry. The bench provokes this by streaming the same code on every clock while it rewrites that entry at one chosen edge. It then checks each output in turn. Samples looked up at or before the write edge must carry the old energy, and every later sample must carry the new one, with no sample lost or repeated.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [1:0] {
    SEL_INPUT = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_NOSH  = 2'd2,
    SEL_NONE  = 2'd3
  } tblSel_e;

  typedef struct packed {
    logic wrIn;
    logic wrCmp;
    logic wrNs;
    logic rdIn;
    logic rdCmp;
    logic rdNs;
  } tpgStrobes_t;

endpackage

// File: rtl/tpgSatSum.sv
module tpgSatSum #(
  parameter int NUM_CH = 4,
  parameter int LIN_W  = 10
) (
  input  logic [NUM_CH*LIN_W-1:0] linFlat,
  output logic [LIN_W-1:0]        sumSat
);
  localparam int GROW_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int ACC_W  = LIN_W + GROW_W;
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'({LIN_W{1'b1}});

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      acc = acc + ACC_W'(linFlat[c*LIN_W +: LIN_W]);
    end
    if (acc > LIMIT) sumSat = '1;
    else             sumSat = acc[LIN_W-1:0];
  end
endmodule

// File: rtl/tpgCtrl.sv
module tpgCtrl import tpg_pkg::*; #(
  parameter int DEPTH = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  cfgSel,
  input  logic        cfgWrEn,
  input  logic        inValid,
  output tpgStrobes_t stb,
  output logic        validOut
);
  tblSel_e selDec;
  logic [DEPTH-1:0] vldPipe;

  always_comb begin
    selDec    = tblSel_e'(cfgSel);
    stb       = '0;
    stb.rdIn  = (selDec == SEL_INPUT);
    stb.rdCmp = (selDec == SEL_CMP);
    stb.rdNs  = (selDec == SEL_NOSH);
    stb.wrIn  = cfgWrEn && stb.rdIn;
    stb.wrCmp = cfgWrEn && stb.rdCmp;
    stb.wrNs  = cfgWrEn && stb.rdNs;
  end

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) vldPipe <= '0;
        else       vldPipe <= inValid;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rstN) vldPipe <= '0;
        else       vldPipe <= {vldPipe[DEPTH-2:0], inValid};
      end
    end
  endgenerate

  assign validOut = vldPipe[DEPTH-1];
endmodule

// File: rtl/tpgPath.sv
module tpgPath import tpg_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int RAW_W  = 6,
  parameter int LIN_W  = 10,
  parameter int CMP_W  = 7,
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH*RAW_W-1:0] inCodes,
  input  logic                    inMuon,
  input  tpgStrobes_t             stb,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [LIN_W-1:0]        cfgWrData,
  output logic [LIN_W-1:0]        cfgRdData,
  output logic [CMP_W-1:0]        etOut,
  output logic                    muonOut
);
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int IN_DEPTH  = 1 << RAW_W;
  localparam int CMP_DEPTH = 1 << LIN_W;
  localparam int NS_DEPTH  = 1 << CMP_W;
  localparam int CMP_MAX   = NS_DEPTH - 1;

  logic [LIN_W-1:0] inLut  [NUM_CH][IN_DEPTH];
  logic [CMP_W-1:0] cmpLut [CMP_DEPTH];
  logic             nsLut  [NS_DEPTH];

  logic [CH_W-1:0]  chIdx;
  logic [RAW_W-1:0] codeIdx;
  logic [LIN_W-1:0] cmpIdx;
  logic [CMP_W-1:0] nsIdx;
  logic             chOk;

  assign chIdx   = cfgAddr[RAW_W +: CH_W];
  assign codeIdx = cfgAddr[RAW_W-1:0];
  assign cmpIdx  = cfgAddr[LIN_W-1:0];
  assign nsIdx   = cfgAddr[CMP_W-1:0];
  assign chOk    = (int'(chIdx) < NUM_CH);

  // Linearizing tables, one per channel
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++)
        for (int e = 0; e < IN_DEPTH; e++)
          inLut[c][e] <= LIN_W'(e);
    end else if (stb.wrIn && chOk) begin
      inLut[chIdx][codeIdx] <= cfgWrData;
    end
  end

  // Compressing table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < CMP_DEPTH; e++)
        cmpLut[e] <= (e > CMP_MAX) ? CMP_W'(CMP_MAX) : CMP_W'(e);
    end else if (stb.wrCmp) begin
      cmpLut[cmpIdx] <= cfgWrData[CMP_W-1:0];
    end
  end

  // No-shower muon qualification table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NS_DEPTH; e++) nsLut[e] <= 1'b1;
    end else if (stb.wrNs) begin
      nsLut[nsIdx] <= cfgWrData[0];
    end
  end

  // Read-back register
  always_ff @(posedge clk) begin
    if (!rstN)                cfgRdData <= '0;
    else if (stb.rdIn && chOk) cfgRdData <= inLut[chIdx][codeIdx];
    else if (stb.rdCmp)       cfgRdData <= LIN_W'(cmpLut[cmpIdx]);
    else if (stb.rdNs)        cfgRdData <= LIN_W'(nsLut[nsIdx]);
    else                      cfgRdData <= '0;
  end

  // Stage 1: per-channel linearization
  logic [LIN_W-1:0] linQ [NUM_CH];
  logic             muon1;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) linQ[c] <= '0;
      muon1 <= 1'b0;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        linQ[c] <= inLut[c][inCodes[c*RAW_W +: RAW_W]];
      muon1 <= inMuon;
    end
  end

  // Stage 2: saturating channel sum
  logic [NUM_CH*LIN_W-1:0] linFlat;
  logic [LIN_W-1:0]        sumD;
  logic [LIN_W-1:0]        sumQ;
  logic                    muon2;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) linFlat[c*LIN_W +: LIN_W] = linQ[c];
  end

  tpgSatSum #(.NUM_CH(NUM_CH), .LIN_W(LIN_W)) u_sum (
    .linFlat(linFlat),
    .sumSat (sumD)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ  <= '0;
      muon2 <= 1'b0;
    end else begin
      sumQ  <= sumD;
      muon2 <= muon1;
    end
  end

  // Stage 3: compression and muon veto
  logic [CMP_W-1:0] cmpCode;
  assign cmpCode = cmpLut[sumQ];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      etOut   <= '0;
      muonOut <= 1'b0;
    end else begin
      etOut   <= cmpCode;
      muonOut <= muon2 & nsLut[cmpCode];
    end
  end
endmodule

// File: rtl/tpgPrimitive.sv
module tpgPrimitive import tpg_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int RAW_W  = 6,
  parameter int LIN_W  = 10,
  parameter int CMP_W  = 7,
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [NUM_CH*RAW_W-1:0] inCodes,
  input  logic                    inMuon,
  input  logic [1:0]              cfgSel,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic                    cfgWrEn,
  input  logic [LIN_W-1:0]        cfgWrData,
  output logic [LIN_W-1:0]        cfgRdData,
  output logic                    outValid,
  output logic [CMP_W-1:0]        outEt,
  output logic                    outMuon
);
  localparam int PIPE_DEPTH = 3;

  tpgStrobes_t stb;

  tpgCtrl #(.DEPTH(PIPE_DEPTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgSel  (cfgSel),
    .cfgWrEn (cfgWrEn),
    .inValid (inValid),
    .stb     (stb),
    .validOut(outValid)
  );

  tpgPath #(
    .NUM_CH(NUM_CH), .RAW_W(RAW_W), .LIN_W(LIN_W),
    .CMP_W(CMP_W), .ADDR_W(ADDR_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .inCodes  (inCodes),
    .inMuon   (inMuon),
    .stb      (stb),
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .etOut    (outEt),
    .muonOut  (outMuon)
  );
endmodule

// File: rtl/tpgChecker.sv
module tpgChecker #(
  parameter int LIN_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inMuon,
  input logic [1:0]       cfgSel,
  input logic [LIN_W-1:0] cfgRdData,
  input logic             outValid,
  input logic             outMuon
);
  a_r6_valid_arrives: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##2 outValid);

  a_r6_idle_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##2 !outValid);

  a_r9_reset_clears: assert property (@(posedge clk)
    !rstN |=> !outValid);

  a_r5_muon_needs_source: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMuon) |-> $past(inMuon, 3));

  a_r10_none_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSel == 2'd3) |=> (cfgRdData == '0));
endmodule

bind tpgPrimitive tpgChecker #(.LIN_W(LIN_W)) u_chk (.*);

// File: tb/sim_tpgPrimitive.sv
module sim_tpgPrimitive;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [23:0] inCodes;
  logic        inMuon;
  logic [1:0]  cfgSel;
  logic [9:0]  cfgAddr;
  logic        cfgWrEn;
  logic [9:0]  cfgWrData;
  logic [9:0]  cfgRdData;
  logic        outValid;
  logic [6:0]  outEt;
  logic        outMuon;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tpgPrimitive u0 (.*);

  // {ch3,ch2,ch1,ch0 codes, muon, expected et, expected muon}
  localparam logic [32:0] VEC [6] = '{
    {6'd0, 6'd0, 6'd0,  6'd0,  1'b1, 7'd0,   1'b1},
    {6'd0, 6'd0, 6'd0,  6'd3,  1'b1, 7'd3,   1'b1},
    {6'd0, 6'd5, 6'd20, 6'd10, 1'b0, 7'd35,  1'b0},
    {6'd0, 6'd0, 6'd63, 6'd63, 1'b1, 7'd126, 1'b1},
    {6'd0, 6'd1, 6'd63, 6'd63, 1'b1, 7'd127, 1'b1},
    {6'd0, 6'd0, 6'd0,  6'd1,  1'b0, 7'd1,   1'b0}
  };

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [9:0] addr, input logic [9:0] data);
    @(negedge clk);
    cfgSel = sel; cfgAddr = addr; cfgWrData = data; cfgWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input string req, input logic [1:0] sel, input logic [9:0] addr, input int exp);
    @(negedge clk);
    cfgSel = sel; cfgAddr = addr; cfgWrEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkEq(req, int'(cfgRdData), exp);
  endtask

  // one sample, output checked in the cycle after the third edge
  task automatic runOne(input string req, input logic [23:0] codes, input logic mu,
                        input int expEt, input int expMu);
    @(negedge clk);
    inCodes = codes; inMuon = mu; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkEq({req, " not valid early"}, int'(outValid), 0);
    @(posedge clk);
    @(negedge clk);
    checkEq({req, " valid"}, int'(outValid), 1);
    checkEq({req, " et"}, int'(outEt), expEt);
    checkEq({req, " muon"}, int'(outMuon), expMu);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inCodes = '0; inMuon = 1'b0;
    cfgSel = 2'd3; cfgAddr = '0; cfgWrEn = 1'b0; cfgWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkEq("R9 valid in reset", int'(outValid), 0);
    checkEq("R9 et in reset", int'(outEt), 0);
    checkEq("R9 muon in reset", int'(outMuon), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R9 valid after reset", int'(outValid), 0);

    // R1 identity contents, seen through read-back
    cfgRead("R1 input ch1 e9", 2'd0, {2'd0, 2'd1, 6'd9}, 9);
    cfgRead("R1 cmp e300", 2'd1, 10'd300, 127);
    cfgRead("R1 cmp e50", 2'd1, 10'd50, 50);
    cfgRead("R1 nosh e4", 2'd2, 10'd4, 1);

    // R1/R6 vector table walk
    for (int i = 0; i < 6; i++) begin
      runOne("R1 R6 vector", VEC[i][32:9], VEC[i][8], int'(VEC[i][7:1]), int'(VEC[i][0]));
    end

    // R2/R3/R4 tables programmed
    cfgWrite(2'd0, {2'd0, 2'd2, 6'd7}, 10'd700);
    cfgWrite(2'd0, {2'd0, 2'd3, 6'd7}, 10'd700);
    cfgWrite(2'd1, 10'd1023, 10'd85);
    cfgWrite(2'd1, 10'd376, 10'd33);
    cfgWrite(2'd1, 10'd700, 10'd44);
    runOne("R3 saturated sum", {6'd7, 6'd7, 6'd0, 6'd0}, 1'b1, 85, 1);
    runOne("R4 single ch2", {6'd0, 6'd7, 6'd0, 6'd0}, 1'b0, 44, 0);
    runOne("R2 ch0 untouched", {6'd0, 6'd0, 6'd0, 6'd7}, 1'b0, 7, 0);

    // R5 muon veto
    cfgWrite(2'd2, 10'd85, 10'd0);
    runOne("R5 vetoed", {6'd7, 6'd7, 6'd0, 6'd0}, 1'b1, 85, 0);
    runOne("R5 passes", {6'd0, 6'd0, 6'd0, 6'd3}, 1'b1, 3, 1);

    // R7 read-back of programmed entries
    cfgRead("R7 input ch2 e7", 2'd0, {2'd0, 2'd2, 6'd7}, 700);
    cfgRead("R7 input ch0 e7", 2'd0, {2'd0, 2'd0, 6'd7}, 7);
    cfgRead("R7 cmp e1023", 2'd1, 10'd1023, 85);
    cfgRead("R7 nosh e85", 2'd2, 10'd85, 0);

    // R10 selector 3 ignored
    cfgWrite(2'd3, 10'd85, 10'd1);
    cfgRead("R10 nosh e85 kept", 2'd2, 10'd85, 0);
    cfgRead("R10 none reads zero", 2'd3, 10'd85, 0);
    runOne("R10 output unchanged", {6'd7, 6'd7, 6'd0, 6'd0}, 1'b1, 85, 0);

    // R8 write racing a stream of lookups of the same entry
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        checkEq("R8 stream valid", int'(outValid), 1);
        checkEq("R8 stream et", int'(outEt), (k - 3 <= 4) ? 5 : 100);
      end
      if (k < 10) begin
        inValid = 1'b1; inCodes = {6'd0, 6'd0, 6'd0, 6'd5}; inMuon = 1'b0;
      end else begin
        inValid = 1'b0;
      end
      if (k == 4) begin
        cfgSel = 2'd0; cfgAddr = {2'd0, 2'd0, 6'd5}; cfgWrData = 10'd100; cfgWrEn = 1'b1;
      end else begin
        cfgWrEn = 1'b0;
      end
    end
    @(negedge clk);
    checkEq("R6 stream drained", int'(outValid), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule